// File: doc/BRIEF.md
# Cache Error Trap Dispatcher

This block sits between the memory-system error detectors and the processor's trap logic. Each error event arrives as a one-cycle strobe with two codes. The first code gives the kind of error and the second gives the operation that found it. From these codes and three enable bits in a control register, the block picks at most one of four trap requests. The choices are a fast cache-ECC trap, an instruction access error, a data access error, or a disrupting ECC error.

The block records every valid event in a sticky status register, whether or not a trap is raised. Software clears the status bits by writing ones to them. The same control register also holds the fields used for ECC error injection. When a force bit is set, its forced check value replaces the computed ECC on the outgoing path.

Top module: `cache_err_trap_dispatch`

## Requirements
- R1: After reset the control register, the status register and all four trap outputs read zero.
- R2: Writable control bits are 0 (corrected-error enable), 1 (uncorrectable/system enable), 3 (fast cache-ECC enable), 4..12 (forced data check), 13 (data force), 14..17 (forced tag check) and 18 (tag force). Every other bit reads zero.
- R3: Class codes 0 (software-correctable cache) and 1 (uncorrectable cache) raise `trap_fast_ecc` when bit 3 is set. This applies only when the op code is 0 (fetch), 1 (load) or 2 (atomic).
- R4: Cache classes 0 and 1 raise no trap for op codes 3 (store merge), 4 (writeback), 5 (copyout) and 6 (interrupt vector fetch).
- R5: Classes 3 (uncorrectable bus data/tag), 4 (bus timeout) and 5 (bus error) with bit 1 set map as follows. Op 0 raises `trap_inst_access`. Ops 1, 2 and 6 raise `trap_data_access`.
- R6: Classes 3, 4 and 5 with bit 1 set raise `trap_disrupt` for ops 3, 4 and 5.
- R7: Class 2 (hardware-corrected) raises `trap_disrupt` for any op 0..6 when bit 0 is set.
- R8: When an event's enable bit is clear, no trap is raised. The event still sets status bit N, where N is the class code.
- R9: Status bits stay set until a clear strobe with a one in that mask position. A clear that coincides with a new event for the same bit leaves the bit set.
- R10: A trap output is a single-cycle pulse that appears the clock after the strobe. At most one trap output is high at a time.
- R11: With a force bit set, the matching forced check value drives the ECC output. Otherwise the ECC input passes through unchanged.
- R12: Class codes 6 and 7 raise no trap and log nothing. Op code 7 raises no trap but still logs the class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error event strobe |
| evt_class | input | 3 | Error class code |
| evt_op | input | 3 | Originating operation code |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | CTL_W | Control register write value |
| ctl_rd_data | output | CTL_W | Control register contents |
| sts_clr_en | input | 1 | Status clear strobe |
| sts_clr_mask | input | 6 | Ones clear the matching status bits |
| sts_rd_data | output | 6 | Sticky status, bit N for class N |
| ecc_tag_in | input | 4 | Computed tag ECC |
| ecc_data_in | input | 9 | Computed data ECC |
| ecc_tag_out | output | 4 | Outgoing tag ECC |
| ecc_data_out | output | 9 | Outgoing data ECC |
| trap_fast_ecc | output | 1 | Fast cache-ECC trap request |
| trap_inst_access | output | 1 | Instruction access error trap request |
| trap_data_access | output | 1 | Data access error trap request |
| trap_disrupt | output | 1 | Disrupting ECC error trap request |

## Verification
The block has three kinds of result, each with its own timing:
- Trap pulses and status updates are due at the first rising edge after the strobe.
- Control register reads show a write after one edge.
- The ECC outputs follow their inputs within the same cycle.

When the driver presents an event or a clear, it stamps the expected item with the next cycle number. The monitor counts cycles just after each rising edge and compares the trap outputs and status only when an item's stamp matches the current cycle. In every other cycle the monitor requires all traps to be low and the status to be unchanged. Control reads are checked one edge after a write, and ECC outputs are checked a short delay after their inputs change.

// File: rtl/ced_pkg.sv
package ced_pkg;

    localparam int NUM_CLASS   = 6;
    localparam int TAG_ECC_W   = 4;
    localparam int DATA_ECC_W  = 9;

    localparam int EN_CORR_BIT  = 0;
    localparam int EN_UNC_BIT   = 1;
    localparam int EN_FAST_BIT  = 3;
    localparam int FDATA_LO     = 4;
    localparam int FDATA_FORCE  = FDATA_LO + DATA_ECC_W;
    localparam int FTAG_LO      = FDATA_FORCE + 1;
    localparam int FTAG_FORCE   = FTAG_LO + TAG_ECC_W;
    localparam int CTL_USED_W   = FTAG_FORCE + 1;

    typedef enum logic [2:0] {
        CLS_CACHE_SOFT = 3'd0,
        CLS_CACHE_UNC  = 3'd1,
        CLS_HW_CORR    = 3'd2,
        CLS_BUS_UE     = 3'd3,
        CLS_BUS_TO     = 3'd4,
        CLS_BUS_ERR    = 3'd5,
        CLS_RSV6       = 3'd6,
        CLS_RSV7       = 3'd7
    } err_class_e;

    typedef enum logic [2:0] {
        OP_IFETCH  = 3'd0,
        OP_LOAD    = 3'd1,
        OP_ATOMIC  = 3'd2,
        OP_MERGE   = 3'd3,
        OP_WBACK   = 3'd4,
        OP_COPYOUT = 3'd5,
        OP_IVEC    = 3'd6,
        OP_RSV     = 3'd7
    } err_op_e;

    typedef struct packed {
        logic disrupt;
        logic dacc;
        logic iacc;
        logic fast;
    } trap_req_t;

    typedef struct packed {
        logic                  tag_force;
        logic [TAG_ECC_W-1:0]  tag_val;
        logic                  data_force;
        logic [DATA_ECC_W-1:0] data_val;
    } inject_t;

    function automatic logic [CTL_USED_W-1:0] ctl_wmask();
        logic [CTL_USED_W-1:0] m;
        m = '0;
        m[EN_CORR_BIT] = 1'b1;
        m[EN_UNC_BIT]  = 1'b1;
        m[EN_FAST_BIT] = 1'b1;
        for (int i = FDATA_LO; i < CTL_USED_W; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic op_local_read(err_op_e op);
        return (op == OP_IFETCH) || (op == OP_LOAD) || (op == OP_ATOMIC);
    endfunction

    function automatic logic op_background(err_op_e op);
        return (op == OP_MERGE) || (op == OP_WBACK) || (op == OP_COPYOUT);
    endfunction

    function automatic logic class_known(err_class_e c);
        return c <= CLS_BUS_ERR;
    endfunction

endpackage

// File: rtl/ced_ctl_reg.sv
module ced_ctl_reg
    import ced_pkg::*;
#(
    parameter int CTL_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CTL_W-1:0]      wr_data,
    output logic [CTL_W-1:0]      rd_data,
    output logic                  en_corr,
    output logic                  en_unc,
    output logic                  en_fast,
    input  logic [TAG_ECC_W-1:0]  tag_in,
    input  logic [DATA_ECC_W-1:0] data_in,
    output logic [TAG_ECC_W-1:0]  tag_out,
    output logic [DATA_ECC_W-1:0] data_out
);
    localparam logic [CTL_W-1:0] WMASK = CTL_W'(ctl_wmask());

    logic [CTL_W-1:0] ctl_q;
    inject_t          inj;

    always_ff @(posedge clk) begin
        if (rst)        ctl_q <= '0;
        else if (wr_en) ctl_q <= wr_data & WMASK;
    end

    assign rd_data = ctl_q;
    assign en_corr = ctl_q[EN_CORR_BIT];
    assign en_unc  = ctl_q[EN_UNC_BIT];
    assign en_fast = ctl_q[EN_FAST_BIT];

    assign inj.tag_force  = ctl_q[FTAG_FORCE];
    assign inj.tag_val    = ctl_q[FTAG_LO +: TAG_ECC_W];
    assign inj.data_force = ctl_q[FDATA_FORCE];
    assign inj.data_val   = ctl_q[FDATA_LO +: DATA_ECC_W];

    always_comb begin
        tag_out  = inj.tag_force  ? inj.tag_val  : tag_in;
        data_out = inj.data_force ? inj.data_val : data_in;
    end
endmodule

// File: rtl/ced_classify.sv
module ced_classify
    import ced_pkg::*;
(
    input  logic                 valid,
    input  logic [2:0]           cls_raw,
    input  logic [2:0]           op_raw,
    input  logic                 en_corr,
    input  logic                 en_unc,
    input  logic                 en_fast,
    output trap_req_t            req,
    output logic [NUM_CLASS-1:0] log_set
);
    err_class_e cls;
    err_op_e    op;

    assign cls = err_class_e'(cls_raw);
    assign op  = err_op_e'(op_raw);

    always_comb begin
        req = '0;
        if (valid) begin
            unique case (cls)
                CLS_CACHE_SOFT, CLS_CACHE_UNC: begin
                    req.fast = en_fast && op_local_read(op);
                end
                CLS_HW_CORR: begin
                    req.disrupt = en_corr && (op != OP_RSV);
                end
                CLS_BUS_UE, CLS_BUS_TO, CLS_BUS_ERR: begin
                    if (en_unc) begin
                        req.iacc    = (op == OP_IFETCH);
                        req.dacc    = (op == OP_LOAD) || (op == OP_ATOMIC) || (op == OP_IVEC);
                        req.disrupt = op_background(op);
                    end
                end
                default: req = '0;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_log
        assign log_set[g] = valid && class_known(cls) && (cls_raw == 3'(g));
    end
endmodule

// File: rtl/ced_status.sv
module ced_status
    import ced_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CLASS-1:0] set,
    input  logic                 clr_en,
    input  logic [NUM_CLASS-1:0] clr_mask,
    output logic [NUM_CLASS-1:0] sts
);
    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)                        bit_q <= 1'b0;
            else if (set[g])                bit_q <= 1'b1;
            else if (clr_en && clr_mask[g]) bit_q <= 1'b0;
        end
        assign sts[g] = bit_q;
    end
endmodule

// File: rtl/cache_err_trap_dispatch.sv
module cache_err_trap_dispatch
    import ced_pkg::*;
#(
    parameter int CTL_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  evt_valid,
    input  logic [2:0]            evt_class,
    input  logic [2:0]            evt_op,
    input  logic                  ctl_wr_en,
    input  logic [CTL_W-1:0]      ctl_wr_data,
    output logic [CTL_W-1:0]      ctl_rd_data,
    input  logic                  sts_clr_en,
    input  logic [NUM_CLASS-1:0]  sts_clr_mask,
    output logic [NUM_CLASS-1:0]  sts_rd_data,
    input  logic [TAG_ECC_W-1:0]  ecc_tag_in,
    input  logic [DATA_ECC_W-1:0] ecc_data_in,
    output logic [TAG_ECC_W-1:0]  ecc_tag_out,
    output logic [DATA_ECC_W-1:0] ecc_data_out,
    output logic                  trap_fast_ecc,
    output logic                  trap_inst_access,
    output logic                  trap_data_access,
    output logic                  trap_disrupt
);
    logic                 en_corr, en_unc, en_fast;
    trap_req_t            req_d, req_q;
    logic [NUM_CLASS-1:0] log_set;

    ced_ctl_reg #(.CTL_W(CTL_W)) ctl_i (
        .clk(clk), .rst(rst),
        .wr_en(ctl_wr_en), .wr_data(ctl_wr_data), .rd_data(ctl_rd_data),
        .en_corr(en_corr), .en_unc(en_unc), .en_fast(en_fast),
        .tag_in(ecc_tag_in), .data_in(ecc_data_in),
        .tag_out(ecc_tag_out), .data_out(ecc_data_out)
    );

    ced_classify cls_i (
        .valid(evt_valid), .cls_raw(evt_class), .op_raw(evt_op),
        .en_corr(en_corr), .en_unc(en_unc), .en_fast(en_fast),
        .req(req_d), .log_set(log_set)
    );

    ced_status sts_i (
        .clk(clk), .rst(rst), .set(log_set),
        .clr_en(sts_clr_en), .clr_mask(sts_clr_mask), .sts(sts_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_d;
    end

    assign trap_fast_ecc    = req_q.fast;
    assign trap_inst_access = req_q.iacc;
    assign trap_data_access = req_q.dacc;
    assign trap_disrupt     = req_q.disrupt;
endmodule

// File: rtl/ced_checker.sv
module ced_checker #(
    parameter int CTL_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             evt_valid,
    input logic [2:0]       evt_class,
    input logic [2:0]       evt_op,
    input logic [CTL_W-1:0] ctl_rd_data,
    input logic             sts_clr_en,
    input logic [5:0]       sts_clr_mask,
    input logic [5:0]       sts_rd_data,
    input logic [3:0]       ecc_tag_in,
    input logic [3:0]       ecc_tag_out,
    input logic [8:0]       ecc_data_in,
    input logic [8:0]       ecc_data_out,
    input logic             trap_fast_ecc,
    input logic             trap_inst_access,
    input logic             trap_data_access,
    input logic             trap_disrupt
);
    assert_single_trap_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trap_fast_ecc, trap_inst_access, trap_data_access, trap_disrupt}));

    assert_trap_needs_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        (trap_fast_ecc || trap_inst_access || trap_data_access || trap_disrupt) |-> $past(evt_valid));

    assert_fast_cause_R3: assert property (@(posedge clk) disable iff (rst)
        trap_fast_ecc |-> ($past(ctl_rd_data[3]) && $past(evt_class) <= 3'd1 && $past(evt_op) <= 3'd2));

    assert_iacc_cause_R5: assert property (@(posedge clk) disable iff (rst)
        trap_inst_access |-> ($past(ctl_rd_data[1]) && $past(evt_op) == 3'd0));

    assert_corr_disrupt_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_class == 3'd2 && evt_op != 3'd7 && ctl_rd_data[0]) |=> trap_disrupt);

    assert_log_timeout_R8: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_class == 3'd4) |=> sts_rd_data[4]);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (sts_rd_data[1] && !(sts_clr_en && sts_clr_mask[1])) |=> sts_rd_data[1]);

    assert_reserved_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_class[2:1] == 2'b11) |=>
        !(trap_fast_ecc || trap_inst_access || trap_data_access || trap_disrupt));

    assert_tag_pass_R11: assert property (@(posedge clk) disable iff (rst)
        !ctl_rd_data[18] |-> ecc_tag_out == ecc_tag_in);

    assert_data_pass_R11: assert property (@(posedge clk) disable iff (rst)
        !ctl_rd_data[13] |-> ecc_data_out == ecc_data_in);
endmodule

bind cache_err_trap_dispatch ced_checker #(.CTL_W(CTL_W)) chk_i (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_class(evt_class), .evt_op(evt_op),
    .ctl_rd_data(ctl_rd_data), .sts_clr_en(sts_clr_en), .sts_clr_mask(sts_clr_mask),
    .sts_rd_data(sts_rd_data), .ecc_tag_in(ecc_tag_in), .ecc_tag_out(ecc_tag_out),
    .ecc_data_in(ecc_data_in), .ecc_data_out(ecc_data_out),
    .trap_fast_ecc(trap_fast_ecc), .trap_inst_access(trap_inst_access),
    .trap_data_access(trap_data_access), .trap_disrupt(trap_disrupt)
);

// File: tb/cache_err_trap_dispatch_tb_top.sv
module cache_err_trap_dispatch_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic [2:0]  evt_class = '0;
    logic [2:0]  evt_op = '0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic [31:0] ctl_rd_data;
    logic        sts_clr_en = 1'b0;
    logic [5:0]  sts_clr_mask = '0;
    logic [5:0]  sts_rd_data;
    logic [3:0]  ecc_tag_in = '0;
    logic [8:0]  ecc_data_in = '0;
    logic [3:0]  ecc_tag_out;
    logic [8:0]  ecc_data_out;
    logic        trap_fast_ecc, trap_inst_access, trap_data_access, trap_disrupt;

    always #2 clk = ~clk;

    cache_err_trap_dispatch dut_i (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_class(evt_class), .evt_op(evt_op),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .sts_clr_en(sts_clr_en), .sts_clr_mask(sts_clr_mask), .sts_rd_data(sts_rd_data),
        .ecc_tag_in(ecc_tag_in), .ecc_data_in(ecc_data_in),
        .ecc_tag_out(ecc_tag_out), .ecc_data_out(ecc_data_out),
        .trap_fast_ecc(trap_fast_ecc), .trap_inst_access(trap_inst_access),
        .trap_data_access(trap_data_access), .trap_disrupt(trap_disrupt)
    );

    typedef struct {
        int         cyc;
        logic [3:0] tr;
        logic [5:0] st;
        string      req;
    } exp_t;

    exp_t        q[$];
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    logic [31:0] ctl_model = '0;
    logic [5:0]  sts_model = '0;

    function automatic logic [3:0] model_trap(int c, int o, logic [31:0] ctl);
        logic [3:0] t;  // {disrupt, dacc, iacc, fast}
        t = '0;
        if (c <= 1) t[0] = ctl[3] && (o <= 2);
        else if (c == 2) t[3] = ctl[0] && (o <= 6);
        else if (c <= 5 && ctl[1]) begin
            if (o == 0) t[1] = 1'b1;
            else if (o == 1 || o == 2 || o == 6) t[2] = 1'b1;
            else if (o >= 3 && o <= 5) t[3] = 1'b1;
        end
        return t;
    endfunction

    function automatic string req_of(int c, int o, logic [31:0] ctl);
        if (c >= 6 || o == 7) return "R12";
        if (c <= 1) return (o <= 2) ? (ctl[3] ? "R3" : "R8") : "R4";
        if (c == 2) return ctl[0] ? "R7" : "R8";
        if (!ctl[1]) return "R8";
        return (o >= 3 && o <= 5) ? "R6" : "R5";
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Driver: called at a negedge; leaves on the next negedge.
    task automatic drive(bit v, int c, int o, bit clr, logic [5:0] mask, string req);
        exp_t it;
        logic [5:0] nxt;
        nxt = sts_model & ~(clr ? mask : 6'h0);
        if (v && c <= 5) nxt[c] = 1'b1;
        it.cyc = cyc + 1;
        it.tr  = v ? model_trap(c, o, ctl_model) : 4'h0;
        it.st  = nxt;
        it.req = req;
        q.push_back(it);
        sts_model    = nxt;
        evt_valid    = v;
        evt_class    = 3'(c);
        evt_op       = 3'(o);
        sts_clr_en   = clr;
        sts_clr_mask = mask;
        @(negedge clk);
        evt_valid  = 1'b0;
        sts_clr_en = 1'b0;
    endtask

    task automatic write_ctl(logic [31:0] val, logic [31:0] exp_rd);
        ctl_wr_en   = 1'b1;
        ctl_wr_data = val;
        @(negedge clk);
        ctl_wr_en = 1'b0;
        ctl_model = exp_rd;
        chk(ctl_rd_data == exp_rd, "R2", "ctl_rd", ctl_rd_data, exp_rd);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            if (!rst) begin
                logic [3:0] act;
                act = {trap_disrupt, trap_data_access, trap_inst_access, trap_fast_ecc};
                if (q.size() > 0 && q[0].cyc == cyc) begin
                    exp_t it;
                    it = q.pop_front();
                    chk(act == it.tr, it.req, "traps", 32'(act), 32'(it.tr));
                    chk(sts_rd_data == it.st, (it.req == "R12" || it.req == "R9") ? it.req : "R8",
                        "status", 32'(sts_rd_data), 32'(it.st));
                end else begin
                    chk(act == 4'h0, "R10", "idle traps", 32'(act), 32'h0);
                    chk(sts_rd_data == sts_model, "R9", "idle status", 32'(sts_rd_data), 32'(sts_model));
                end
            end
        end
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] ctl_list [5];
        ctl_list = '{32'h0B, 32'h0, 32'h1, 32'h2, 32'h8};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ctl_rd_data == 0, "R1", "ctl", ctl_rd_data, 0);
        chk(sts_rd_data == 0, "R1", "sts", 32'(sts_rd_data), 0);
        chk({trap_disrupt, trap_data_access, trap_inst_access, trap_fast_ecc} == 0,
            "R1", "traps", 0, 0);

        // R2 write mask
        write_ctl(32'hFFFF_FFFF, 32'h0007_FFFB);
        write_ctl(32'h0, 32'h0);

        // R11 injection
        ecc_tag_in  = 4'h3;
        ecc_data_in = 9'h0A5;
        #1;
        chk(ecc_tag_out == 4'h3 && ecc_data_out == 9'h0A5, "R11", "pass",
            {ecc_tag_out, 3'b0, ecc_data_out}, {4'h3, 3'b0, 9'h0A5});
        @(negedge clk);
        write_ctl((32'h1 << 18) | (32'hA << 14) | (32'h155 << 4), (32'h1 << 18) | (32'hA << 14) | (32'h155 << 4));
        chk(ecc_tag_out == 4'hA, "R11", "tag forced", 32'(ecc_tag_out), 32'hA);
        chk(ecc_data_out == 9'h0A5, "R11", "data pass", 32'(ecc_data_out), 32'h0A5);
        write_ctl((32'h1 << 13) | (32'h1C3 << 4), (32'h1 << 13) | (32'h1C3 << 4));
        chk(ecc_data_out == 9'h1C3, "R11", "data forced", 32'(ecc_data_out), 32'h1C3);
        chk(ecc_tag_out == 4'h3, "R11", "tag pass", 32'(ecc_tag_out), 32'h3);

        // R3..R8, R12: every class x op under several enable settings
        foreach (ctl_list[k]) begin
            write_ctl(ctl_list[k], ctl_list[k]);
            for (int c = 0; c < 8; c++) begin
                for (int o = 0; o < 8; o++) begin
                    drive(1'b1, c, o, 1'b0, 6'h0, req_of(c, o, ctl_model));
                end
            end
            drive(1'b0, 0, 0, 1'b1, 6'h3F, "R9");
        end

        // R9 sticky and clear corner cases
        write_ctl(32'h0, 32'h0);
        drive(1'b1, 3, 1, 1'b0, 6'h0, "R8");
        drive(1'b1, 5, 4, 1'b0, 6'h0, "R8");
        drive(1'b0, 0, 0, 1'b0, 6'h0, "R9");
        drive(1'b0, 0, 0, 1'b1, 6'h08, "R9");   // clear bit 3, keep bit 5
        drive(1'b1, 5, 0, 1'b1, 6'h20, "R9");   // coincident set wins
        drive(1'b0, 0, 0, 1'b1, 6'h20, "R9");
        // R10 back-to-back pulses
        write_ctl(32'h2, 32'h2);
        drive(1'b1, 4, 0, 1'b0, 6'h0, "R5");
        drive(1'b1, 4, 0, 1'b0, 6'h0, "R5");
        drive(1'b0, 0, 0, 1'b0, 6'h0, "R10");
        repeat (3) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule